// File: doc/BRIEF.md
# Data Address Watchpoint Unit

This block watches the load/store bus of a processor and raises a debug exception when an access lands inside a watched address window. It has six comparators. Each one holds an inclusive lower and upper 32-bit bound and a two-bit direction field. The direction fields for all six sit in one shared configuration word. A single enable bit in the condition/status word gates the whole unit.

On each valid access, every comparator checks its own range against the access independently. Comparators whose windows overlap can match together. When more than one matches, the lowest-numbered comparator is reported. A hit produces a one-cycle exception pulse on the edge after the access. The same edge loads a status word with a fixed cause code and the index of the winning comparator, and latches the access address. Both the status word and the latched address hold until the next hit.

Top module: `dwatch_unit`

## Requirements
- R1: After reset, `exc_pulse`, `exc_status` and `exc_addr` are zero, all direction fields, bounds and the global enable are clear, and no access raises a hit until software configures the unit.
- R2: Comparator n takes its direction from `cfg_wdata[2+4n+1:2+4n]`. Bit value 1 allows read hits and bit value 2 allows write hits, so 3 allows both. A field of 0 never hits.
- R3: An access hits comparator n only when `lo_n <= acc_addr <= hi_n` as an unsigned 32-bit comparison, with both bounds inclusive.
- R4: The global enable is bit 19 of `ccs_wdata`, stored when `ccs_we` is high. While it is clear, no comparator hits.
- R5: A hit makes `exc_pulse` high for exactly the cycle after the access. The same edge sets `exc_status[15:8]` to 0x0C and `exc_status[2:0]` to the index of the reported comparator. All other status bits read zero.
- R6: On a hit, `exc_addr` takes the access address. `exc_addr` and `exc_status` hold their values until the next hit.
- R7: When several comparators hit in the same cycle, the lowest-numbered one is reported.
- R8: A configuration, enable or bound write made in the same cycle as an access takes effect only for later accesses. The access itself is judged against the values held before the write.
- R9: An access with `acc_valid` low never hits.
- R10: Configuration bits outside the six direction fields (bits 1:0, 5:4 of each slot, and 31:26) have no effect on hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the direction configuration word |
| cfg_wdata | input | 32 | Configuration word; comparator n's field is at bits 2+4n+1:2+4n |
| ccs_we | input | 1 | Write strobe for the condition/status word |
| ccs_wdata | input | 32 | Condition/status word; bit 19 is the global enable |
| rng_we | input | 1 | Write strobe for a bound register |
| rng_sel | input | 3 | Comparator index for the bound write (values above 5 are ignored) |
| rng_hi | input | 1 | 1 writes the upper bound, 0 writes the lower bound |
| rng_wdata | input | 32 | Bound value |
| acc_valid | input | 1 | Access on the bus this cycle |
| acc_rd | input | 1 | Access is a read |
| acc_wr | input | 1 | Access is a write |
| acc_addr | input | 32 | Access data address |
| exc_pulse | output | 1 | One-cycle debug exception request |
| exc_status | output | 32 | Cause 0x0C in bits 15:8, reported comparator index in bits 2:0 |
| exc_addr | output | 32 | Address of the most recent hitting access |

## Verification
Two things can fall in the same cycle. First, several comparators can match one access. Second, a register write can coincide with an access. The first is provoked by giving two comparators the same window and hitting it. The status index must name the lower comparator, and after that comparator's field is cleared it must name the higher one. The second is provoked by changing a direction field or a bound in the very cycle of an access. The scoreboard's model applies the write only after judging the access, so any sign of the new value acting early shows up as a mismatch on the next cycle.

// File: rtl/dwatch_unit.sv
module dwatch_unit #(
  parameter int NWP    = 6,
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int EN_BIT = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          ccs_we,
  input  logic [DW-1:0] ccs_wdata,
  input  logic          rng_we,
  input  logic [2:0]    rng_sel,
  input  logic          rng_hi,
  input  logic [AW-1:0] rng_wdata,
  input  logic          acc_valid,
  input  logic          acc_rd,
  input  logic          acc_wr,
  input  logic [AW-1:0] acc_addr,
  output logic          exc_pulse,
  output logic [DW-1:0] exc_status,
  output logic [AW-1:0] exc_addr
);
  localparam int SLOT  = 4;
  localparam int FBASE = 2;
  localparam int IW    = 3;
  localparam logic [7:0] CAUSE = 8'h0C;

  logic [1:0]    dir_q [NWP];
  logic [AW-1:0] lo_q  [NWP];
  logic [AW-1:0] hi_q  [NWP];
  logic          en_q;
  logic [NWP-1:0] hit;
  logic [IW-1:0] win;
  logic [7:0]    cause_q;
  logic [IW-1:0] idx_q;
  logic          unused_bits;

  assign unused_bits = ^{cfg_wdata, ccs_wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      for (int n = 0; n < NWP; n++) begin
        dir_q[n] <= '0;
        lo_q[n]  <= '0;
        hi_q[n]  <= '0;
      end
    end else begin
      if (ccs_we) en_q <= ccs_wdata[EN_BIT];
      for (int n = 0; n < NWP; n++) begin
        if (cfg_we) dir_q[n] <= cfg_wdata[FBASE+SLOT*n +: 2];
        if (rng_we && rng_sel == IW'(n)) begin
          if (rng_hi) hi_q[n] <= rng_wdata;
          else        lo_q[n] <= rng_wdata;
        end
      end
    end
  end

  for (genvar n = 0; n < NWP; n++) begin : g_cmp
    assign hit[n] = acc_valid && en_q
                  && ((dir_q[n][0] && acc_rd) || (dir_q[n][1] && acc_wr))
                  && (acc_addr >= lo_q[n]) && (acc_addr <= hi_q[n]);
  end

  always_comb begin
    win = '0;
    for (int i = NWP-1; i >= 0; i--)
      if (hit[i]) win = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_pulse <= 1'b0;
      cause_q   <= '0;
      idx_q     <= '0;
      exc_addr  <= '0;
    end else begin
      exc_pulse <= |hit;
      if (|hit) begin
        cause_q  <= CAUSE;
        idx_q    <= win;
        exc_addr <= acc_addr;
      end
    end
  end

  assign exc_status = {{(DW-16){1'b0}}, cause_q, {(8-IW){1'b0}}, idx_q};

  // R5
  cause_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_pulse |-> exc_status[15:8] == CAUSE);
  // R6
  addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_pulse |-> exc_addr == $past(acc_addr));
  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_pulse |-> $stable(exc_addr) && $stable(exc_status));
  // R9
  no_invalid_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !exc_pulse);
  // R4
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !exc_pulse);
  // R2
  dir_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd && !acc_wr |=> !exc_pulse);
  // R7
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_pulse |-> exc_status[2:0] < IW'(NWP));
endmodule

// File: tb/test_dwatch_unit.sv
`timescale 1ns/1ps
module test_dwatch_unit;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, ccs_we = 0, rng_we = 0, rng_hi = 0;
  logic [31:0] cfg_wdata = 0, ccs_wdata = 0, rng_wdata = 0, acc_addr = 0;
  logic [2:0] rng_sel = 0;
  logic acc_valid = 0, acc_rd = 0, acc_wr = 0;
  logic exc_pulse;
  logic [31:0] exc_status, exc_addr;

  always #2 clk = ~clk;

  dwatch_unit i_dwatch_unit (.*);

  typedef struct packed { logic p; logic [31:0] s; logic [31:0] a; } item_t;
  item_t exp_q[$];
  string tag_q[$];
  int total = 0, bad = 0;
  bit done = 0;

  logic [31:0] m_cfg = 0, m_lo [6], m_hi [6], m_st = 0, m_ad = 0;
  logic m_en = 0;

  task automatic cyc(input logic cw, input logic [31:0] cd, input logic gw, input logic [31:0] gd,
                     input logic rw, input logic [2:0] rs, input logic rh, input logic [31:0] rdat,
                     input logic v, input logic r, input logic w, input logic [31:0] a, input string tag);
    int win;
    item_t it;
    @(negedge clk);
    cfg_we = cw; cfg_wdata = cd; ccs_we = gw; ccs_wdata = gd;
    rng_we = rw; rng_sel = rs; rng_hi = rh; rng_wdata = rdat;
    acc_valid = v; acc_rd = r; acc_wr = w; acc_addr = a;
    win = -1;
    for (int n = 5; n >= 0; n--) begin
      logic [1:0] f;
      f = m_cfg[2+4*n +: 2];
      if (v && m_en && ((f[0] && r) || (f[1] && w)) && a >= m_lo[n] && a <= m_hi[n]) win = n;
    end
    if (win >= 0) begin
      m_st = {16'h0, 8'h0C, 5'b0, 3'(win)};
      m_ad = a;
    end
    it.p = (win >= 0); it.s = m_st; it.a = m_ad;
    exp_q.push_back(it); tag_q.push_back(tag);
    if (cw) m_cfg = cd;
    if (gw) m_en = gd[19];
    if (rw && rs < 6) begin
      if (rh) m_hi[rs] = rdat; else m_lo[rs] = rdat;
    end
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic wcfg(input logic [31:0] d);
    cyc(1, d, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "cfg");
  endtask
  task automatic wccs(input logic [31:0] d);
    cyc(0, 0, 1, d, 0, 0, 0, 0, 0, 0, 0, 0, "ccs");
  endtask
  task automatic wrng(input logic [2:0] s, input logic [31:0] lo, input logic [31:0] hi);
    cyc(0, 0, 0, 0, 1, s, 0, lo, 0, 0, 0, 0, "rng");
    cyc(0, 0, 0, 0, 1, s, 1, hi, 0, 0, 0, 0, "rng");
  endtask
  task automatic acc(input logic r, input logic w, input logic [31:0] a, input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, r, w, a, tag);
  endtask

  task automatic check(input string tag, input item_t got, input item_t exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got p=%0b st=%h ad=%h exp p=%0b st=%h ad=%h",
               tag, got.p, got.s, got.a, exp.p, exp.s, exp.a);
    end
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0) begin
        item_t g;
        g.p = exc_pulse; g.s = exc_status; g.a = exc_addr;
        check(tag_q.pop_front(), g, exp_q.pop_front());
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [31:0] CFG_A = 32'h00C0_0084;

  initial begin : driver
    for (int n = 0; n < 6; n++) begin m_lo[n] = 0; m_hi[n] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", {exc_pulse, exc_status, exc_addr}, '0);
    rst_n = 1;
    acc(1, 1, 32'h0, "R1 no hit after reset");
    acc(1, 0, 32'h100, "R1 unconfigured");
    wccs(32'h0008_0000);
    wrng(0, 32'h100, 32'h103);
    wrng(1, 32'h200, 32'h2FF);
    wrng(5, 32'h8000_0000, 32'hFFFF_FFFF);
    wcfg(CFG_A);
    acc(1, 0, 32'h100, "R3 R5 low bound read");
    acc(1, 0, 32'h103, "R3 high bound read");
    acc(1, 0, 32'h104, "R3 above range");
    acc(1, 0, 32'hFF, "R3 below range");
    idle("R6 hold");
    acc(0, 1, 32'h101, "R2 write on read-only");
    acc(0, 1, 32'h250, "R2 write-only hit");
    acc(1, 0, 32'h250, "R2 read on write-only");
    acc(1, 0, 32'hFFFF_FFFF, "R3 unsigned top");
    acc(0, 1, 32'h8000_0000, "R2 both dirs write");
    acc(1, 0, 32'h7FFF_FFFF, "R3 unsigned below");
    acc(0, 0, 32'h100, "R2 no direction");
    wrng(2, 32'h300, 32'h310);
    wrng(3, 32'h300, 32'h310);
    wcfg(CFG_A | 32'h0000_CC00);
    acc(1, 0, 32'h305, "R7 lowest wins");
    acc(0, 1, 32'h310, "R7 lowest wins write");
    wcfg(CFG_A | 32'h0000_C000);
    acc(1, 0, 32'h305, "R7 next after clear");
    wcfg(32'hFF00_0033);
    acc(1, 0, 32'h100, "R10 unused bits");
    acc(0, 1, 32'h250, "R10 unused bits");
    acc(1, 1, 32'hFFFF_FFFF, "R10 unused bits");
    wcfg(CFG_A);
    wccs(32'hFFF7_FFFF);
    acc(1, 0, 32'h100, "R4 gate off");
    acc(1, 1, 32'h8000_0004, "R4 gate off");
    wccs(32'h0008_0000);
    acc(1, 0, 32'h102, "R4 gate on");
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 32'h100, "R8 cfg clear same cycle");
    acc(1, 0, 32'h100, "R8 cfg clear applied");
    cyc(1, CFG_A, 0, 0, 0, 0, 0, 0, 1, 1, 0, 32'h101, "R8 cfg set same cycle");
    acc(1, 0, 32'h101, "R8 cfg set applied");
    cyc(0, 0, 0, 0, 1, 0, 1, 32'hFF, 1, 1, 0, 32'h100, "R8 bound same cycle");
    acc(1, 0, 32'h100, "R8 bound applied");
    cyc(0, 0, 1, 0, 0, 0, 0, 0, 1, 0, 1, 32'h2AA, "R8 enable same cycle");
    acc(0, 1, 32'h2AA, "R8 enable applied");
    wccs(32'h0008_0000);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h250, "R9 invalid");
    acc(0, 1, 32'h2FF, "R5 back to back");
    acc(1, 0, 32'hC000_0000, "R5 back to back");
    idle("R6 hold");
    idle("R5 pulse single");
    repeat (3) @(posedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule